// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

This block is a small binary up counter, four bits wide by default, that advances on the rising clock edge. Its value can be preset from a data bus, and it can be cleared at once at any time. Two active-high enables must both be high for the value to advance. The first, `cnt_en`, is a plain count enable. The second, `carry_in`, is the chaining input. Only `carry_in` also qualifies the terminal-count output `carry_out`.

To build a wider synchronous counter, instances share one clock, one clear, one load strobe and one `cnt_en`. Each stage's `carry_out` feeds the `carry_in` of the next, more significant stage, so no extra gating is needed. The control inputs have a fixed priority. Clear comes first and acts without a clock. Load comes second and overrides both enables. Counting comes last.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros. The clear takes effect without a clock edge and wins over load and both enables.
- R2: With `clr_n` high and `ld_n` low, `q` takes the value of `din` at the next rising edge, whatever `cnt_en` and `carry_in` are.
- R3: With `clr_n` and `ld_n` high and both `cnt_en` and `carry_in` high, `q` increases by one at each rising edge.
- R4: With `clr_n` and `ld_n` high and either enable low, `q` keeps its value across the rising edge.
- R5: `carry_out` is high exactly when `carry_in` is high and `q` is all ones. `cnt_en` has no effect on it.
- R6: `carry_out` follows a change on `carry_in` within the same clock cycle, without waiting for an edge.
- R7: An enabled count from the all-ones value gives all zeros.
- R8: When three stages are chained (each `carry_out` driving the next `carry_in`, with `cnt_en`, `ld_n` and `clr_n` shared), the joined outputs count as one 12-bit binary counter. This holds through a load or a clear in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| clr_n | input | 1 | Active-low asynchronous clear |
| ld_n | input | 1 | Active-low synchronous preset strobe |
| cnt_en | input | 1 | Count enable; does not affect carry_out |
| carry_in | input | 1 | Chaining count enable; also gates carry_out |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag, high when carry_in is high and q is all ones |

## Verification
Load, count and hold results appear on `q` at the first rising edge after the inputs are set up. The driver sets the inputs at the falling edge and queues the value expected after the following rising edge. The monitor pops that entry one time unit after the rising edge and compares `q`, `carry_out` and the joined three-stage value. Clear and the response of `carry_out` to `carry_in` need no edge. These are checked one time unit after the input change, inside the low half of the clock, so that no rising edge comes between the stimulus and the sample.

// File: rtl/casc_counter_pkg.sv
// Shared types for the cascadable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package casc_counter_pkg;

    // Operation chosen for the next rising edge (clear is handled separately, asynchronously)
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/casc_counter_ctrl.sv
// Control decode: picks the synchronous operation by fixed priority
// (load, then count, then hold). Assumes clear is applied downstream.
module casc_counter_ctrl
    import casc_counter_pkg::*;
(
    input  logic    ld_n,
    input  logic    cnt_en,
    input  logic    carry_in,
    output cnt_op_e op
);

    // Priority decode of the preset strobe and the two count enables
    always_comb begin
        if (!ld_n) begin
            op = OP_LOAD;
        end else if (cnt_en && carry_in) begin
            op = OP_INC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/casc_counter_next.sv
// Next-state logic: look-ahead incrementer plus a selector for the operation.
// Assumes WIDTH >= 1. Each bit toggles when all lower bits are one.
module casc_counter_next
    import casc_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH-1:0] toggle;
    logic [WIDTH-1:0] inc_val;

    // Look-ahead toggle chain: bit 0 always toggles
    assign toggle[0] = 1'b1;
    for (genvar i = 1; i < WIDTH; i++) begin : g_look
        assign toggle[i] = toggle[i-1] & cur[i-1];
    end

    assign inc_val = cur ^ toggle;

    // Select the next value from the decoded operation
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC:  nxt = inc_val;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/casc_counter_reg.sv
// State register with active-low asynchronous clear.
// Assumes clr_n is synchronised to clk by the user on release.
module casc_counter_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);

    // Hold the count; clear wins immediately, otherwise capture nxt on the rising edge
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/casc_counter_carry.sv
// Terminal-count detector: combinational, so a carry_in change reaches
// carry_out without a clock. Assumes cur comes straight from the register.
module casc_counter_carry #(
    parameter int WIDTH = 4
) (
    input  logic             carry_in,
    input  logic [WIDTH-1:0] cur,
    output logic             carry_out
);

    // Flag the all-ones state, qualified only by the chaining enable
    always_comb begin
        carry_out = carry_in && (&cur);
    end

endmodule

// File: rtl/casc_counter.sv
// Top: one cascadable counter stage. Chain stages by wiring carry_out to the
// next carry_in and sharing clk, clr_n, ld_n and cnt_en.
module casc_counter
    import casc_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    cnt_op_e          op;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    casc_counter_ctrl u_ctrl (
        .ld_n     (ld_n),
        .cnt_en   (cnt_en),
        .carry_in (carry_in),
        .op       (op)
    );

    casc_counter_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (cur),
        .din (din),
        .nxt (nxt)
    );

    casc_counter_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    casc_counter_carry #(.WIDTH(WIDTH)) u_carry (
        .carry_in  (carry_in),
        .cur       (cur),
        .carry_out (carry_out)
    );

    assign q = cur;

endmodule

// File: rtl/casc_counter_sva.sv
// Port-level checker for casc_counter, bound to every instance.
// Assumes clr_n is the only reset; 'armed' delays |=> checks until one edge out of clear.
module casc_counter_sva #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic             cnt_en,
    input logic             carry_in,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    logic armed;

    // Set once a rising edge has passed with clear released
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> (q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && !ld_n) |=> (q == $past(din)));

    p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && ld_n && cnt_en && carry_in) |=> (q == WIDTH'($past(q) + 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && ld_n && !(cnt_en && carry_in)) |=> $stable(q));

    p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !carry_in |-> !carry_out);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && ld_n && cnt_en && carry_out) |=> (q == '0));

endmodule

bind casc_counter casc_counter_sva #(.WIDTH(WIDTH)) u_sva (
    .clk       (clk),
    .clr_n     (clr_n),
    .ld_n      (ld_n),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/casc_counter_test.sv
// Scoreboard bench: a single stage plus a three-stage chain share all controls.
module casc_counter_test;

    localparam int CLK_P = 10;
    localparam int W     = 4;
    localparam int NST   = 3;
    localparam int WW    = W * NST;

    typedef struct {
        logic [W-1:0]  q;
        logic          c;
        logic [WW-1:0] w;
        logic          wc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          clr_n, ld_n, cnt_en, carry_in;
    logic [W-1:0]  din;
    logic [WW-1:0] din_w;
    logic [W-1:0]  q;
    logic          carry_out;
    logic [WW-1:0] q_w;
    logic [NST:0]  chain;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [W-1:0]  mdl_q;
    logic [WW-1:0] mdl_w;

    always #(CLK_P/2) clk = ~clk;

    casc_counter #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .din(din), .q(q), .carry_out(carry_out)
    );

    assign chain[0] = carry_in;
    for (genvar k = 0; k < NST; k++) begin : g_stage
        casc_counter #(.WIDTH(W)) u_st (
            .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
            .carry_in(chain[k]), .din(din_w[k*W +: W]),
            .q(q_w[k*W +: W]), .carry_out(chain[k+1])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: set inputs at the falling edge and queue the result due after the next rising edge
    task automatic step(input logic l_n, input logic en, input logic ci,
                        input logic [W-1:0] d, input logic [WW-1:0] dw, input string tag);
        exp_t e;
        @(negedge clk);
        ld_n = l_n; cnt_en = en; carry_in = ci; din = d; din_w = dw;
        if (!l_n) begin
            mdl_q = d; mdl_w = dw;
        end else if (en && ci) begin
            mdl_q = mdl_q + 1'b1; mdl_w = mdl_w + 1'b1;
        end
        e.q = mdl_q; e.c = ci && (&mdl_q);
        e.w = mdl_w; e.wc = ci && (&mdl_w);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one time unit after each rising edge, compare against the queued entry
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " q"}, 32'(q), 32'(e.q));
            check({e.tag, " carry_out (R5)"}, 32'(carry_out), 32'(e.c));
            check({e.tag, " chain (R8)"}, 32'(q_w), 32'(e.w));
            check({e.tag, " chain carry (R8)"}, 32'(chain[NST]), 32'(e.wc));
        end
    end

    // Mid-count clear, held over an edge with load asserted (R1, R8)
    task automatic clear_mid;
        @(negedge clk);
        ld_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
        #1 clr_n = 1'b0;
        #1;
        check("R1 async clear q", 32'(q), 32'h0);
        check("R8 async clear chain", 32'(q_w), 32'h0);
        @(negedge clk);
        ld_n = 1'b0; cnt_en = 1'b1; carry_in = 1'b1; din = 4'h9; din_w = 12'h999;
        @(posedge clk);
        #1;
        check("R1 clear over load q", 32'(q), 32'h0);
        check("R1 clear over load chain", 32'(q_w), 32'h0);
        @(negedge clk);
        ld_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
        clr_n = 1'b1;
        mdl_q = '0; mdl_w = '0;
    endtask

    initial begin
        clr_n = 1'b1; ld_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
        din = '0; din_w = '0; mdl_q = '0; mdl_w = '0;
        #1 clr_n = 1'b0;
        #1;
        check("R1 reset q", 32'(q), 32'h0);
        check("R1 reset carry_out", 32'(carry_out), 32'h0);
        @(negedge clk);
        @(negedge clk);
        clr_n = 1'b1;

        step(1'b0, 1'b0, 1'b0, 4'hA, 12'h3F0, "R2 load enables low");
        step(1'b0, 1'b1, 1'b1, 4'h3, 12'hAB5, "R2 load enables high");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 4'h0, 12'h0, "R3 R7 count");
        step(1'b1, 1'b0, 1'b1, 4'h5, 12'h555, "R4 hold cnt_en low");
        step(1'b1, 1'b1, 1'b0, 4'h5, 12'h555, "R4 hold carry_in low");
        step(1'b1, 1'b0, 1'b0, 4'h5, 12'h555, "R4 hold both low");
        step(1'b0, 1'b1, 1'b1, 4'hE, 12'h0FD, "R2 load near top");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 4'h0, 12'h0, "R7 R8 wrap");

        // Carry follows carry_in with no edge; cnt_en has no effect (R5, R6)
        step(1'b0, 1'b0, 1'b1, 4'hF, 12'hFFF, "R2 load all ones");
        @(negedge clk);
        cnt_en = 1'b0; carry_in = 1'b0;
        #1 check("R6 carry drops with carry_in", 32'(carry_out), 32'h0);
        carry_in = 1'b1;
        #1 check("R6 carry rises with carry_in", 32'(carry_out), 32'h1);
        cnt_en = 1'b1;
        #1 check("R5 cnt_en no effect on carry", 32'(carry_out), 32'h1);
        cnt_en = 1'b0;
        #1 check("R5 cnt_en low keeps carry", 32'(carry_out), 32'h1);
        check("R8 chain carry all ones", 32'(chain[NST]), 32'h1);
        ld_n = 1'b1;

        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 4'h0, 12'h0, "R7 R8 count");
        clear_mid();
        for (int i = 0; i < 18; i++) step(1'b1, 1'b1, 1'b1, 4'h0, 12'h0, "R3 R8 after clear");
        step(1'b0, 1'b1, 1'b1, 4'h7, 12'hFE8, "R2 R8 mid-count load");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, 4'h0, 12'h0, "R3 R7 R8 long count");
        step(1'b1, 1'b0, 1'b1, 4'h0, 12'h0, "R4 final hold");
        @(negedge clk);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule